// File: doc/BRIEF.md
# Hit-Driven Channel Readout Selector

This block sits inside one digitizer module of a hexagonally segmented detector. Every pixel whose signal passes one of its three discriminator levels puts a hit word on a shared trigger bus. A hit word carries the pixel number and a 2-bit level code. Each clock, the selector takes in every hit word present on the bus lanes. It turns each valid hit into a lookup address built from the pixel number and the level, and reads a per-module table entry at that address. It then ORs the entries into one mask of local channels to read out.

Software fills the table before enabling the trigger. In a typical load, a hit on any pixel selects that pixel and its six hexagonal neighbours, wherever they sit among this module's channels. Because the table is indexed by level as well as by pixel, one pixel can select a different channel set at each level. Every module decides independently from the same broadcast. Downstream capture logic uses the resulting mask together with a one-cycle readout strobe.

Top module: `hit_readout_sel`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the outputs `rd_mask` and `rd_strobe` are cleared at that edge. Every table entry is set to zero.
- R2: A hit word is `{level[1:0], pixel[6:0]}`, with the pixel number in bits 6..0 and the level code in bits 8..7. Bus lane s uses bits `s*9 +: 9` of `hit_words`. A valid hit reads the table entry at address `{pixel, level}`.
- R3: A hit whose level code is 00 means "no hit". It contributes an all-zero mask even when the table entry at its address is non-zero.
- R4: A hit whose pixel number is `N_PIX` (127) or higher contributes an all-zero mask, whatever the table holds at its address.
- R5: The table entries selected by all hits captured at the same edge are ORed into a single `rd_mask`. This holds also when the same hit appears on several lanes.
- R6: Hits captured at rising edge k appear on `rd_mask` after rising edge k+2. Captures at consecutive edges give results at consecutive edges, and a cycle with no hits gives an all-zero mask.
- R7: `rd_strobe` is high for exactly those cycles in which `rd_mask` is non-zero.
- R8: A table write stores `cfg_data` at address `cfg_addr = {pixel, level}` when `cfg_we` is high and `trig_en` is low. A write attempted while `trig_en` is high is ignored and leaves the entry unchanged.
- R9: Hits presented while `trig_en` is low are not captured and produce an all-zero mask.
- R10: Each level of a pixel has its own table entry, so levels 01, 10 and 11 of one pixel can select different channel sets.
- R11: A lane whose `hit_valid` bit is low contributes nothing, whatever its hit word holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig_en | input | 1 | High: capture hits, block table writes |
| hit_valid | input | N_SLOTS | Per-lane hit qualifier |
| hit_words | input | N_SLOTS*9 | Packed hit words, `{level, pixel}` per lane |
| cfg_we | input | 1 | Table write enable |
| cfg_addr | input | 9 | Table address `{pixel, level}` |
| cfg_data | input | N_CH | Channel mask to store |
| rd_mask | output | N_CH | Combined channel readout mask |
| rd_strobe | output | 1 | High when `rd_mask` is non-zero |

## Verification
The bench builds the selector with three bus lanes, 16 channels and the full 127-pixel address space. Three lanes are enough to drive a three-way OR of distinct entries, a duplicated hit on two lanes, and a mix of valid and rejected hits in one cycle. The full 7-bit pixel field puts address 127 within reach, so a populated table entry at an out-of-range pixel shows that the range check, and not an empty table, suppresses the hit.

// File: rtl/hrs_pkg.sv
// Shared definitions for the hit readout selector.
// Assumes the level code is always 2 bits wide.
package hrs_pkg;
    localparam int LVL_W = 2;

    typedef enum logic [LVL_W-1:0] {
        LVL_NONE = 2'b00,
        LVL_LOW  = 2'b01,
        LVL_MID  = 2'b10,
        LVL_HIGH = 2'b11
    } level_e;
endpackage

// File: rtl/hrs_hit_decode.sv
// Decodes one bus lane: splits the hit word and decides whether the hit
// is usable. Assumes the word layout {level, pixel}.
module hrs_hit_decode
    import hrs_pkg::*;
#(
    parameter int PIX_W = 7,
    parameter int N_PIX = 127,
    localparam int WORD_W = PIX_W + LVL_W
) (
    input  logic              en,
    input  logic              valid,
    input  logic [WORD_W-1:0] word,
    output logic              usable,
    output logic [WORD_W-1:0] index
);
    localparam logic [PIX_W:0] PIX_LIMIT = (PIX_W+1)'(N_PIX);

    logic [PIX_W-1:0] pix;
    level_e           lvl;

    // Split the word into its fields.
    always_comb begin
        pix = word[PIX_W-1:0];
        lvl = level_e'(word[WORD_W-1:PIX_W]);
    end

    // Qualify the hit and form the table address {pixel, level}.
    always_comb begin
        usable = en && valid && (lvl != LVL_NONE) && ({1'b0, pix} < PIX_LIMIT);
        index  = {pix, word[WORD_W-1:PIX_W]};
    end
endmodule

// File: rtl/hrs_table.sv
// Readout lookup table: one channel mask per {pixel, level} address,
// a single write port and one combinational read port per lane.
// Assumes the caller gates writes.
module hrs_table #(
    parameter int IDX_W   = 9,
    parameter int N_CH    = 16,
    parameter int N_SLOTS = 4,
    localparam int N_ENT  = 2 ** IDX_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [IDX_W-1:0]         wr_addr,
    input  logic [N_CH-1:0]          wr_data,
    input  logic [N_SLOTS*IDX_W-1:0] rd_addr,
    output logic [N_SLOTS*N_CH-1:0]  rd_data
);
    logic [N_CH-1:0] mem [N_ENT];

    // Clear all entries on reset, otherwise store the gated write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < N_ENT; e++) mem[e] <= '0;
        end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // One read port per lane.
    for (genvar s = 0; s < N_SLOTS; s++) begin : g_rd
        assign rd_data[s*N_CH +: N_CH] = mem[rd_addr[s*IDX_W +: IDX_W]];
    end
endmodule

// File: rtl/hrs_merge.sv
// Registers the looked-up masks per lane, ORs them and registers the
// result with a strobe. Assumes rd_ok/rd_data are aligned.
module hrs_merge #(
    parameter int N_CH    = 16,
    parameter int N_SLOTS = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_SLOTS-1:0]      lane_ok,
    input  logic [N_SLOTS*N_CH-1:0] lane_mask,
    output logic [N_CH-1:0]         mask_q,
    output logic                    strobe_q
);
    logic [N_SLOTS-1:0][N_CH-1:0] held;
    logic [N_CH-1:0]              merged;

    // Latch each lane's mask, zeroed when the lane holds no usable hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held <= '0;
        end else begin
            for (int s = 0; s < N_SLOTS; s++)
                held[s] <= lane_ok[s] ? lane_mask[s*N_CH +: N_CH] : '0;
        end
    end

    // OR all lane masks together.
    always_comb begin
        merged = '0;
        for (int s = 0; s < N_SLOTS; s++) merged = merged | held[s];
    end

    // Register the combined mask and its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q   <= '0;
            strobe_q <= 1'b0;
        end else begin
            mask_q   <= merged;
            strobe_q <= |merged;
        end
    end
endmodule

// File: rtl/hit_readout_sel.sv
// Top: captures bus hits, looks up per-hit channel masks and merges them.
// Pipeline: capture at edge k, lookup registered at k+1, output at k+2.
// Assumes table writes happen only with the trigger disabled.
module hit_readout_sel
    import hrs_pkg::*;
#(
    parameter int N_SLOTS = 4,
    parameter int PIX_W   = 7,
    parameter int N_PIX   = 127,
    parameter int N_CH    = 16,
    localparam int WORD_W = PIX_W + LVL_W,
    localparam int IDX_W  = PIX_W + LVL_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      trig_en,
    input  logic [N_SLOTS-1:0]        hit_valid,
    input  logic [N_SLOTS*WORD_W-1:0] hit_words,
    input  logic                      cfg_we,
    input  logic [IDX_W-1:0]          cfg_addr,
    input  logic [N_CH-1:0]           cfg_data,
    output logic [N_CH-1:0]           rd_mask,
    output logic                      rd_strobe
);
    logic [N_SLOTS-1:0]       dec_ok;
    logic [N_SLOTS*IDX_W-1:0] dec_idx;
    logic [N_SLOTS-1:0]       cap_ok;
    logic [N_SLOTS*IDX_W-1:0] cap_idx;
    logic [N_SLOTS*N_CH-1:0]  tbl_data;
    logic                     wr_ok;

    for (genvar s = 0; s < N_SLOTS; s++) begin : g_lane
        hrs_hit_decode #(.PIX_W(PIX_W), .N_PIX(N_PIX)) u_dec (
            .en     (trig_en),
            .valid  (hit_valid[s]),
            .word   (hit_words[s*WORD_W +: WORD_W]),
            .usable (dec_ok[s]),
            .index  (dec_idx[s*IDX_W +: IDX_W])
        );
    end

    // Capture the decoded hits of this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_ok  <= '0;
            cap_idx <= '0;
        end else begin
            cap_ok  <= dec_ok;
            cap_idx <= dec_idx;
        end
    end

    // Writes are accepted only while the trigger is off.
    assign wr_ok = cfg_we && !trig_en;

    hrs_table #(.IDX_W(IDX_W), .N_CH(N_CH), .N_SLOTS(N_SLOTS)) u_tbl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_ok),
        .wr_addr (cfg_addr),
        .wr_data (cfg_data),
        .rd_addr (cap_idx),
        .rd_data (tbl_data)
    );

    hrs_merge #(.N_CH(N_CH), .N_SLOTS(N_SLOTS)) u_mrg (
        .clk       (clk),
        .rst_n     (rst_n),
        .lane_ok   (cap_ok),
        .lane_mask (tbl_data),
        .mask_q    (rd_mask),
        .strobe_q  (rd_strobe)
    );
endmodule

// File: rtl/hrs_checker.sv
// Port-level checks for hit_readout_sel, bound to every instance.
// Keeps a three-deep record of whether any usable hit was presented.
module hrs_checker #(
    parameter int N_SLOTS = 4,
    parameter int PIX_W   = 7,
    parameter int N_PIX   = 127,
    parameter int N_CH    = 16
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         trig_en,
    input logic [N_SLOTS-1:0]           hit_valid,
    input logic [N_SLOTS*(PIX_W+2)-1:0] hit_words,
    input logic [N_CH-1:0]              rd_mask,
    input logic                         rd_strobe
);
    localparam int WW = PIX_W + 2;

    logic       any_good;
    logic [2:0] hist;

    // Independent view of whether this cycle offers any usable hit.
    always_comb begin
        any_good = 1'b0;
        for (int s = 0; s < N_SLOTS; s++) begin
            if (trig_en && hit_valid[s] && (hit_words[s*WW+PIX_W] | hit_words[s*WW+PIX_W+1])
                && (int'(hit_words[s*WW +: PIX_W]) < N_PIX))
                any_good = 1'b1;
        end
    end

    // Shift the record along by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) hist <= '0;
        else        hist <= {hist[1:0], any_good};
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (rd_mask == '0 && !rd_strobe));

    // R3, R4, R6, R9, R11: no usable hit two edges back gives an empty mask
    p_no_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !hist[2] |-> (rd_mask == '0));

    p_strobe_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe |-> (rd_mask != '0));

    p_mask_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_mask != '0) |-> rd_strobe);
endmodule

bind hit_readout_sel hrs_checker #(
    .N_SLOTS(N_SLOTS), .PIX_W(PIX_W), .N_PIX(N_PIX), .N_CH(N_CH)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .trig_en   (trig_en),
    .hit_valid (hit_valid),
    .hit_words (hit_words),
    .rd_mask   (rd_mask),
    .rd_strobe (rd_strobe)
);

// File: tb/sim_hit_readout_sel.sv
// Scoreboard bench: step() drives one cycle and queues its expected
// result; the monitor compares each result two edges after capture.
module sim_hit_readout_sel;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 3;
    localparam int NC = 16;

    typedef struct {
        logic [NC-1:0] mask;
        string         tag;
    } exp_t;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            trig_en = 1'b0;
    logic [NS-1:0]   hit_valid = '0;
    logic [NS*9-1:0] hit_words = '0;
    logic            cfg_we = 1'b0;
    logic [8:0]      cfg_addr = '0;
    logic [NC-1:0]   cfg_data = '0;
    logic [NC-1:0]   rd_mask;
    logic            rd_strobe;

    int   n_checks = 0;
    int   n_fails = 0;
    exp_t sb[$];
    logic [NC-1:0] model [512];

    hit_readout_sel #(.N_SLOTS(NS), .PIX_W(7), .N_PIX(127), .N_CH(NC)) u0 (
        .clk(clk), .rst_n(rst_n), .trig_en(trig_en), .hit_valid(hit_valid),
        .hit_words(hit_words), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_data(cfg_data), .rd_mask(rd_mask), .rd_strobe(rd_strobe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [8:0] hw(input int pix, input int lvl);
        return {lvl[1:0], pix[6:0]};
    endfunction

    // Drive one cycle and queue the mask it must produce.
    task automatic step(input logic en, input logic [NS-1:0] v,
                        input logic [8:0] w0, input logic [8:0] w1, input logic [8:0] w2,
                        input logic we, input logic [8:0] a, input logic [NC-1:0] d,
                        input string tag);
        logic [8:0]    w [NS];
        logic [NC-1:0] e;
        exp_t          it;
        @(negedge clk);
        w[0] = w0; w[1] = w1; w[2] = w2;
        trig_en = en; hit_valid = v; hit_words = {w2, w1, w0};
        cfg_we = we; cfg_addr = a; cfg_data = d;
        e = '0;
        for (int s = 0; s < NS; s++)
            if (en && v[s] && w[s][8:7] != 2'b00 && w[s][6:0] != 7'd127)
                e = e | model[{w[s][6:0], w[s][8:7]}];
        it.mask = e; it.tag = tag;
        sb.push_back(it);
        if (we && !en) model[a] = d;
    endtask

    task automatic wr(input int pix, input int lvl, input logic [NC-1:0] d);
        step(1'b0, '0, '0, '0, '0, 1'b1, {pix[6:0], lvl[1:0]}, d, "R8");
    endtask

    task automatic idle(input string tag);
        step(1'b1, '0, '0, '0, '0, 1'b0, '0, '0, tag);
    endtask

    // Monitor: pop the item captured two edges ago and compare.
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (sb.size() == 3) begin
                exp_t it;
                it = sb.pop_front();
                n_checks++;
                if (rd_mask !== it.mask || rd_strobe !== (it.mask != '0)) begin
                    n_fails++;
                    $display("FAIL %s/R7 actual mask=%h strobe=%b expected mask=%h strobe=%b",
                             it.tag, rd_mask, rd_strobe, it.mask, it.mask != '0);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_fails++;
        $display("FAIL watchdog R6 actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 512; i++) model[i] = '0;
        repeat (4) @(posedge clk);
        #(CLK_PERIOD/4);
        n_checks++;   // R1 reset state
        if (rd_mask !== '0 || rd_strobe !== 1'b0) begin
            n_fails++;
            $display("FAIL R1 actual mask=%h strobe=%b expected mask=0000 strobe=0",
                     rd_mask, rd_strobe);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R8: table loads, including entries that must never be selected
        wr(5, 1, 16'h0003);
        wr(5, 2, 16'h00F0);
        wr(5, 3, 16'hFF00);
        wr(20, 1, 16'h0100);
        wr(126, 3, 16'h8001);
        wr(0, 2, 16'h0010);
        wr(127, 1, 16'hFFFF);
        wr(9, 0, 16'h0F0F);

        step(1'b1, 3'b001, hw(5, 1), '0, '0, 1'b0, '0, '0, "R2");
        idle("R6");
        step(1'b1, 3'b010, '0, hw(5, 2), '0, 1'b0, '0, '0, "R10");
        step(1'b1, 3'b100, '0, '0, hw(5, 3), 1'b0, '0, '0, "R10");
        step(1'b1, 3'b111, hw(5, 1), hw(20, 1), hw(126, 3), 1'b0, '0, '0, "R5");
        step(1'b1, 3'b001, hw(9, 0), '0, '0, 1'b0, '0, '0, "R3");
        step(1'b1, 3'b010, '0, hw(127, 1), '0, 1'b0, '0, '0, "R4");
        step(1'b1, 3'b011, hw(0, 2), hw(127, 1), '0, 1'b0, '0, '0, "R4");
        step(1'b1, 3'b010, hw(5, 3), hw(0, 2), hw(20, 1), 1'b0, '0, '0, "R11");
        step(1'b1, 3'b001, hw(20, 1), '0, '0, 1'b0, '0, '0, "R6");
        step(1'b1, 3'b001, hw(0, 2), '0, '0, 1'b0, '0, '0, "R6");
        step(1'b0, 3'b111, hw(5, 3), hw(5, 1), hw(126, 3), 1'b0, '0, '0, "R9");
        idle("R9");
        // R8: write attempted with the trigger on must not land
        step(1'b1, 3'b000, '0, '0, '0, 1'b1, {7'd20, 2'd1}, 16'hAAAA, "R8");
        step(1'b1, 3'b001, hw(20, 1), '0, '0, 1'b0, '0, '0, "R8");
        step(1'b1, 3'b011, hw(5, 1), hw(5, 1), '0, 1'b0, '0, '0, "R5");
        step(1'b1, 3'b101, hw(126, 3), '0, hw(5, 2), 1'b0, '0, '0, "R5");
        repeat (4) idle("R6");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule